// File: doc/BRIEF.md
# Shared Configuration Memory Arbiter

This block lets two independent requesters share a 256-byte configuration array and a bank of eight configuration registers. One requester is the card-bus host; the other is the local controller on the card. Each side presents an already-decoded request with a write flag, a space select, an address and write data. It holds the request until the block acknowledges. Requests are brought into a single arbitration timebase. That timebase is a clock-enable derived from the input clock by a 2-bit programmable divider. All array accesses, acknowledges and handshake flags move only on that timebase.

Both ports are served in the same arbitration step when they touch different locations. When they touch the same location and at least one of them writes, the host goes first. In that case a local read sees the host's new data, and a host read sees the old data before the local write lands. Two writes to the same location keep the host value, and the local write is dropped while still being acknowledged.

Two flags carry write notifications between the sides. An active-high interrupt tells the local controller that the host wrote. An active-low status-change line tells the host that the local side wrote, when that notification is enabled. The local side reaches a private control register through a separate select. That register holds the notification enable and a write-one-to-clear bit for the interrupt.

Top module: `attr_arbiter`

## Requirements
- R1: With divider code `divSel` = 0, 1, 2, 3, the arbitration enable `arbTick` is high on exactly one clock in every 1, 2, 4 or 8 clocks respectively.
- R2: Each port uses a four-phase handshake: raise `*Req`, wait for `*Ack` high, drop `*Req`, wait for `*Ack` low. A read's data is valid on `*Rdata` while `*Ack` is high. The array space (`*CfgSel`=0) and the register space (`*CfgSel`=1) are separate.
- R3: In the register space only address bits [2:0] select one of the eight registers, so address 0x0B reaches register 3.
- R4: When both ports write the same location in the same arbitration step, the host value is stored, the local value is discarded, and both ports are acknowledged.
- R5: On a same-location read/write collision, the host access completes first. A local read that collides with a host write returns the host's new value. A host read that collides with a local write returns the previous value, and the local write is stored afterwards.
- R6: A host write to either space sets `irqToLocal`. A local write to the control register (`locCtlSel`=1) with data bit 6 = 1 clears it. The same write with bit 6 = 0 leaves it unchanged.
- R7: A local write to either space drives `stsChgN` low when control bit 2 is 1, and has no effect on `stsChgN` when control bit 2 is 0. Any host read of either space returns `stsChgN` to high.
- R8: When a local write and a host read are served in the same arbitration step, `stsChgN` ends low.
- R9: `hostAck`, `locAck`, `irqToLocal` and `stsChgN` change only on a clock at which `arbTick` was high.
- R10: A local read of the control register returns the notification enable in bit 2 and zero in all other bits.
- R11: After reset, both acknowledges are low, `irqToLocal` is low, `stsChgN` is high, the enable is 0, and every array location and register reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock for the divider and all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| divSel | input | 2 | Arbitration divider code (divide by 2^divSel) |
| arbTick | output | 1 | Arbitration enable, one clock wide |
| hostReq | input | 1 | Host request, held until acknowledged |
| hostWe | input | 1 | Host write (1) or read (0) |
| hostCfgSel | input | 1 | Host targets the register space |
| hostAddr | input | 8 | Host address |
| hostWdata | input | 8 | Host write data |
| hostAck | output | 1 | Host acknowledge |
| hostRdata | output | 8 | Host read data |
| locReq | input | 1 | Local request, held until acknowledged |
| locWe | input | 1 | Local write (1) or read (0) |
| locCfgSel | input | 1 | Local targets the register space |
| locCtlSel | input | 1 | Local targets its private control register |
| locAddr | input | 8 | Local address |
| locWdata | input | 8 | Local write data |
| locAck | output | 1 | Local acknowledge |
| locRdata | output | 8 | Local read data |
| irqToLocal | output | 1 | Host-wrote notification, active high |
| stsChgN | output | 1 | Local-wrote notification, active low |

## Verification
Several properties are checked on every cycle: the divider never produces back-to-back enables at the slower codes, two same-cell writes never happen in one step, and a host write never coincides with a local read of the same cell. The same per-cycle checks cover flag setting after host writes and enabled local writes, acknowledges that rise only after a synchronized request, and outputs that stay still off the enable. The data a port actually receives can only be shown by bench scenarios that launch both ports on the same step. That covers the host-first ordering of a collision, the dropped local value in a write/write clash, and the final level of the status line when a set and a clear coincide.

// File: rtl/attr_arb_pkg.sv
package attr_arb_pkg;
  localparam int CTL_EN_BIT  = 2;
  localparam int CTL_CLR_BIT = 6;

  typedef struct packed {
    logic hWr;
    logic hRd;
    logic hCfg;
    logic lWr;
    logic lRd;
    logic lCfg;
    logic lCtl;
  } arb_stb_t;
endpackage

// File: rtl/attr_arb_clkdiv.sv
module attr_arb_clkdiv #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] divSel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(divSel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign tick = ((cnt & mask) == '0);

  // R1: at any slower code the enable is never high two clocks in a row
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divSel != '0) |=> (!tick || divSel == '0));
endmodule

// File: rtl/attr_arb_ctrl.sv
module attr_arb_ctrl
  import attr_arb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic              hostCfgSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              locReq,
  input  logic              locWe,
  input  logic              locCfgSel,
  input  logic              locCtlSel,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic              ctlClrBit,
  input  logic              ctlEnBit,
  output arb_stb_t          stb,
  output logic              hostAck,
  output logic              locAck,
  output logic              irqToLocal,
  output logic              stsChgN,
  output logic              ctlEn
);
  logic [1:0] hSyncQ, lSyncQ;
  logic hSync, lSync, hPend, lPend;
  logic sameSpace, sameAddr, collide, bothWr;
  logic serveH, serveL, ctlWr;
  logic stsFlag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hSyncQ <= '0;
      lSyncQ <= '0;
    end else if (tick) begin
      hSyncQ <= {hSyncQ[0], hostReq};
      lSyncQ <= {lSyncQ[0], locReq};
    end
  end

  assign hSync = hSyncQ[1];
  assign lSync = lSyncQ[1];
  assign hPend = hSync && !hostAck;
  assign lPend = lSync && !locAck;

  assign sameSpace = (hostCfgSel == locCfgSel) && !locCtlSel;
  assign sameAddr  = hostCfgSel ? (hostAddr[CFG_AW-1:0] == locAddr[CFG_AW-1:0])
                                : (hostAddr == locAddr);
  assign collide = hPend && lPend && sameSpace && sameAddr && (hostWe || locWe);
  assign bothWr  = collide && hostWe && locWe;

  // host always goes first; local waits one step unless both write
  assign serveH = tick && hPend;
  assign serveL = tick && lPend && (!collide || bothWr);
  assign ctlWr  = serveL && locWe && locCtlSel;

  always_comb begin
    stb.hWr  = serveH && hostWe;
    stb.hRd  = serveH && !hostWe;
    stb.hCfg = hostCfgSel;
    stb.lWr  = serveL && locWe && !locCtlSel && !bothWr;
    stb.lRd  = serveL && !locWe;
    stb.lCfg = locCfgSel;
    stb.lCtl = locCtlSel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hostAck    <= 1'b0;
      locAck     <= 1'b0;
      irqToLocal <= 1'b0;
      stsFlag    <= 1'b0;
      ctlEn      <= 1'b0;
    end else if (tick) begin
      if (serveH)                hostAck <= 1'b1;
      else if (hostAck && !hSync) hostAck <= 1'b0;
      if (serveL)                locAck <= 1'b1;
      else if (locAck && !lSync)  locAck <= 1'b0;
      // set wins over clear in both flags
      if (stb.hWr)                 irqToLocal <= 1'b1;
      else if (ctlWr && ctlClrBit) irqToLocal <= 1'b0;
      if (stb.lWr && ctlEn)        stsFlag <= 1'b1;
      else if (stb.hRd)            stsFlag <= 1'b0;
      if (ctlWr) ctlEn <= ctlEnBit;
    end
  end

  assign stsChgN = !stsFlag;

  // R4: never two writes into the same cell in one step
  p_single_writer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.hWr && stb.lWr) |-> !(stb.hCfg == stb.lCfg && sameAddr));
  // R6: a host write always leaves the interrupt set
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.hWr |=> irqToLocal);
  // R7: an enabled local write always leaves the status line low
  p_sts_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.lWr && ctlEn) |=> !stsChgN);
  // R9: outputs hold still between arbitration enables
  p_tick_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(hostAck) && $stable(locAck) && $stable(irqToLocal) && $stable(stsChgN)));
  // R2: an acknowledge only rises for a synchronized request
  p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hostAck) |-> $past(hSync));
endmodule

// File: rtl/attr_arb_datapath.sv
module attr_arb_datapath
  import attr_arb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CFG_N  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  arb_stb_t          stb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [DATA_W-1:0] locWdata,
  input  logic              ctlEn,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] locRdata
);
  localparam int MEM_D  = 1 << ADDR_W;
  localparam int CFG_AW = $clog2(CFG_N);

  logic [DATA_W-1:0] memArr [MEM_D];
  logic [DATA_W-1:0] cfgArr [CFG_N];
  logic [DATA_W-1:0] ctlValue;
  logic [CFG_AW-1:0] hIdx, lIdx;

  assign hIdx = hostAddr[CFG_AW-1:0];
  assign lIdx = locAddr[CFG_AW-1:0];

  always_comb begin
    ctlValue = '0;
    ctlValue[CTL_EN_BIT] = ctlEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_D; i++) memArr[i] <= '0;
      for (int i = 0; i < CFG_N; i++) cfgArr[i] <= '0;
    end else begin
      if (stb.lWr) begin
        if (stb.lCfg) cfgArr[lIdx] <= locWdata;
        else          memArr[locAddr] <= locWdata;
      end
      if (stb.hWr) begin
        if (stb.hCfg) cfgArr[hIdx] <= hostWdata;
        else          memArr[hostAddr] <= hostWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hostRdata <= '0;
      locRdata  <= '0;
    end else begin
      if (stb.hRd) hostRdata <= stb.hCfg ? cfgArr[hIdx] : memArr[hostAddr];
      if (stb.lRd) locRdata  <= stb.lCtl ? ctlValue
                              : (stb.lCfg ? cfgArr[lIdx] : memArr[locAddr]);
    end
  end

  // R5: a cell is never read by one port while the other writes it
  p_no_rw_same_cell_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.hWr && stb.lRd && !stb.lCtl && stb.hCfg == stb.lCfg)
      |-> (stb.hCfg ? hIdx != lIdx : hostAddr != locAddr));
  p_no_wr_rd_same_cell_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.lWr && stb.hRd && stb.hCfg == stb.lCfg)
      |-> (stb.lCfg ? hIdx != lIdx : hostAddr != locAddr));
endmodule

// File: rtl/attr_arbiter.sv
module attr_arbiter
  import attr_arb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CFG_N  = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  divSel,
  output logic              arbTick,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic              hostCfgSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              locReq,
  input  logic              locWe,
  input  logic              locCfgSel,
  input  logic              locCtlSel,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [DATA_W-1:0] locWdata,
  output logic              locAck,
  output logic [DATA_W-1:0] locRdata,
  output logic              irqToLocal,
  output logic              stsChgN
);
  localparam int CFG_AW = $clog2(CFG_N);

  arb_stb_t stb;
  logic     ctlEn;

  attr_arb_clkdiv #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .divSel(divSel), .tick(arbTick)
  );

  attr_arb_ctrl #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(arbTick),
    .hostReq(hostReq), .hostWe(hostWe), .hostCfgSel(hostCfgSel), .hostAddr(hostAddr),
    .locReq(locReq), .locWe(locWe), .locCfgSel(locCfgSel), .locCtlSel(locCtlSel),
    .locAddr(locAddr),
    .ctlClrBit(locWdata[CTL_CLR_BIT]), .ctlEnBit(locWdata[CTL_EN_BIT]),
    .stb(stb), .hostAck(hostAck), .locAck(locAck),
    .irqToLocal(irqToLocal), .stsChgN(stsChgN), .ctlEn(ctlEn)
  );

  attr_arb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_N(CFG_N)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .locAddr(locAddr), .locWdata(locWdata), .ctlEn(ctlEn),
    .hostRdata(hostRdata), .locRdata(locRdata)
  );
endmodule

// File: tb/attr_arbiter_tb.sv
module attr_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] divSel = 2'd0;
  logic arbTick;
  logic hostReq = 0, hostWe = 0, hostCfgSel = 0;
  logic [7:0] hostAddr = 0, hostWdata = 0;
  logic hostAck;
  logic [7:0] hostRdata;
  logic locReq = 0, locWe = 0, locCfgSel = 0, locCtlSel = 0;
  logic [7:0] locAddr = 0, locWdata = 0;
  logic locAck;
  logic [7:0] locRdata;
  logic irqToLocal, stsChgN;

  int checks = 0;
  int errors = 0;
  int monErrs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  attr_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .divSel(divSel), .arbTick(arbTick),
    .hostReq(hostReq), .hostWe(hostWe), .hostCfgSel(hostCfgSel), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostAck(hostAck), .hostRdata(hostRdata),
    .locReq(locReq), .locWe(locWe), .locCfgSel(locCfgSel), .locCtlSel(locCtlSel),
    .locAddr(locAddr), .locWdata(locWdata), .locAck(locAck), .locRdata(locRdata),
    .irqToLocal(irqToLocal), .stsChgN(stsChgN)
  );

  // row: {isLocal, we, cfg, addr, wdata, expected read}
  localparam int NV = 10;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 8'h10, 8'hA5, 8'h00},
    {1'b1, 1'b0, 1'b0, 8'h10, 8'h00, 8'hA5},
    {1'b1, 1'b1, 1'b1, 8'h03, 8'h3C, 8'h00},
    {1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 8'h3C},
    {1'b0, 1'b0, 1'b0, 8'h03, 8'h00, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'hFF, 8'h81, 8'h00},
    {1'b1, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h81},
    {1'b1, 1'b1, 1'b0, 8'h00, 8'h7E, 8'h00},
    {1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h7E},
    {1'b0, 1'b0, 1'b1, 8'h0B, 8'h00, 8'h3C}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostOp(input logic we, input logic cfg, input logic [7:0] a,
                        input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    hostWe = we; hostCfgSel = cfg; hostAddr = a; hostWdata = d; hostReq = 1'b1;
    while (!hostAck) @(negedge clk);
    rd = hostRdata;
    hostReq = 1'b0;
    while (hostAck) @(negedge clk);
  endtask

  task automatic locOp(input logic we, input logic cfg, input logic ctl,
                       input logic [7:0] a, input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    locWe = we; locCfgSel = cfg; locCtlSel = ctl; locAddr = a; locWdata = d; locReq = 1'b1;
    while (!locAck) @(negedge clk);
    rd = locRdata;
    locReq = 1'b0;
    while (locAck) @(negedge clk);
  endtask

  // R9 monitor: outputs may only change after a clock where arbTick was high
  logic [3:0] prevOut;
  logic prevTick;
  bit prevValid = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prevValid && ({hostAck, locAck, irqToLocal, stsChgN} != prevOut) && !prevTick)
        monErrs++;
      prevOut   = {hostAck, locAck, irqToLocal, stsChgN};
      prevTick  = arbTick;
      prevValid = 1;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd, rd2;
    int cnt;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 hostAck", {7'd0, hostAck}, 8'h00);
    chk("R11 locAck", {7'd0, locAck}, 8'h00);
    chk("R11 irq", {7'd0, irqToLocal}, 8'h00);
    chk("R11 stsChgN", {7'd0, stsChgN}, 8'h01);
    rst_n = 1'b1;
    hostOp(1'b0, 1'b0, 8'h20, 8'h00, rd);
    chk("R11 mem reset", rd, 8'h00);
    locOp(1'b0, 1'b1, 1'b0, 8'h05, 8'h00, rd);
    chk("R11 cfg reset", rd, 8'h00);
    locOp(1'b0, 1'b0, 1'b1, 8'h00, 8'h00, rd);
    chk("R11 ctl reset", rd, 8'h00);

    // R1 divider rates
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); divSel = 2'(c);
      cnt = 0;
      repeat (64) begin @(negedge clk); if (arbTick) cnt++; end
      chk("R1 tick count", 8'(cnt), 8'(64 >> c));
    end

    // R9 with slowest divider: one host write while the monitor watches
    divSel = 2'd3;
    hostOp(1'b1, 1'b0, 8'h90, 8'h5A, rd);
    hostOp(1'b0, 1'b0, 8'h90, 8'h00, rd);
    chk("R2 slow divider readback", rd, 8'h5A);
    @(negedge clk); divSel = 2'd0;

    // R2/R3 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][26]) locOp(VEC[i][25], VEC[i][24], 1'b0, VEC[i][23:16], VEC[i][15:8], rd);
      else            hostOp(VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:8], rd);
      if (!VEC[i][25]) chk(VEC[i][24] ? "R3 register read" : "R2 table read", rd, VEC[i][7:0]);
    end

    // R6 interrupt clear
    chk("R6 irq after host writes", {7'd0, irqToLocal}, 8'h01);
    locOp(1'b1, 1'b0, 1'b1, 8'h00, 8'h00, rd);
    chk("R6 bit6=0 keeps irq", {7'd0, irqToLocal}, 8'h01);
    locOp(1'b1, 1'b0, 1'b1, 8'h00, 8'h40, rd);
    chk("R6 bit6=1 clears irq", {7'd0, irqToLocal}, 8'h00);
    hostOp(1'b1, 1'b1, 8'h01, 8'h99, rd);
    chk("R6 host reg write sets irq", {7'd0, irqToLocal}, 8'h01);
    locOp(1'b1, 1'b0, 1'b1, 8'h00, 8'h44, rd);
    chk("R6 clear again", {7'd0, irqToLocal}, 8'h00);

    // R10 control readback
    locOp(1'b0, 1'b0, 1'b1, 8'h00, 8'h00, rd);
    chk("R10 ctl readback", rd, 8'h04);

    // R7 status-change line
    locOp(1'b1, 1'b0, 1'b0, 8'h30, 8'h12, rd);
    chk("R7 enabled local write", {7'd0, stsChgN}, 8'h00);
    hostOp(1'b0, 1'b0, 8'h30, 8'h00, rd);
    chk("R7 host read releases", {7'd0, stsChgN}, 8'h01);
    locOp(1'b1, 1'b0, 1'b1, 8'h00, 8'h00, rd);
    locOp(1'b1, 1'b1, 1'b0, 8'h02, 8'h34, rd);
    chk("R7 disabled local write", {7'd0, stsChgN}, 8'h01);
    locOp(1'b1, 1'b0, 1'b1, 8'h00, 8'h04, rd);

    // R4 write/write collision
    fork
      hostOp(1'b1, 1'b0, 8'h40, 8'h11, rd);
      locOp(1'b1, 1'b0, 1'b0, 8'h40, 8'h22, rd2);
    join
    hostOp(1'b0, 1'b0, 8'h40, 8'h00, rd);
    chk("R4 host value kept", rd, 8'h11);
    fork
      hostOp(1'b1, 1'b1, 8'h06, 8'h55, rd);
      locOp(1'b1, 1'b1, 1'b0, 8'h0E, 8'h66, rd2);
    join
    locOp(1'b0, 1'b1, 1'b0, 8'h06, 8'h00, rd);
    chk("R4 register clash host wins", rd, 8'h55);

    // R5 read/write collisions
    hostOp(1'b1, 1'b0, 8'h50, 8'hAA, rd);
    fork
      hostOp(1'b1, 1'b0, 8'h50, 8'hBB, rd);
      locOp(1'b0, 1'b0, 1'b0, 8'h50, 8'h00, rd2);
    join
    chk("R5 local read sees host write", rd2, 8'hBB);
    hostOp(1'b0, 1'b0, 8'h00, 8'h00, rd);   // clears status line
    fork
      hostOp(1'b0, 1'b0, 8'h60, 8'h00, rd);
      locOp(1'b1, 1'b0, 1'b0, 8'h60, 8'hCC, rd2);
    join
    chk("R5 host read sees old value", rd, 8'h00);
    chk("R8 status after serialized clash", {7'd0, stsChgN}, 8'h00);
    hostOp(1'b0, 1'b0, 8'h60, 8'h00, rd);
    chk("R5 local write landed", rd, 8'hCC);

    // R8 same-step local write and host read
    chk("R8 precondition released", {7'd0, stsChgN}, 8'h01);
    fork
      hostOp(1'b0, 1'b0, 8'h71, 8'h00, rd);
      locOp(1'b1, 1'b0, 1'b0, 8'h70, 8'h3E, rd2);
    join
    chk("R8 status ends low", {7'd0, stsChgN}, 8'h00);

    // R9 monitor result
    chk("R9 outputs move only on tick", 8'(monErrs), 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule